// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block turns a configuration request, made of a bus number, a device/function number and a register offset, into two values. The first is the 24-bit offset into the configuration window. The second is the 16-bit value for the window's map register, which tells the bridge what kind of bus cycle to run. A request on bus 0 targets the local segment and becomes a type 0 access. A request on any other bus is forwarded to other buses as a type 1 access. Running the bus cycle and reprogramming the windows are left to other logic.

On the local segment the one-hot device-select line is split. Slots 0 to 12 set address bit slot+11 directly in the window offset. Slots 13 and up set map bit slot−5, which lies in the map value's high-address field. Because the map value is 16 bits wide, only slots 13 to 20 can be selected there. Slots 21 to 31 get no select bit at all. The slot is devfn[7:3] and the function is devfn[2:0].

A small two-state controller governs timing. In ST_IDLE it waits. On a request it moves to ST_EMIT (transition IDLE_TO_EMIT), and it stays in ST_EMIT while requests keep arriving in consecutive cycles (EMIT_HOLD). When a cycle passes with no request it returns to ST_IDLE (EMIT_TO_IDLE). If there is no request while it is in ST_IDLE, it stays there (IDLE_WAIT). The valid strobe is high exactly while the controller is in ST_EMIT.

Top module: `cfgaddr_gen`

## Requirements
- R1: While reset is held and right after it, valid is 0 and both cfg_addr and cfg_map are 0.
- R2: valid is 1 in the cycle after each cycle in which req is 1, and 0 in the cycle after each cycle in which req is 0. Back-to-back requests give back-to-back valid cycles.
- R3: A request with bus 0 is type 0. Its map bit 0 is 0, cfg_addr[1:0] is 0, cfg_addr[10:8] equals devfn[2:0], and cfg_addr[7:2] equals offset[7:2].
- R4: For type 0 with slot devfn[7:3] ≤ 12, cfg_addr bit (slot+11) is 1, every other bit of cfg_addr[23:11] is 0, and cfg_map[15:4] is 0.
- R5: For type 0 with slot from 13 to 20, cfg_map bit (slot−5) is 1, every other bit of cfg_map[15:4] is 0, and cfg_addr[23:11] is 0.
- R6: For type 0 with slot from 21 to 31, cfg_addr[23:11] and cfg_map[15:4] are both 0.
- R7: A request with a nonzero bus is type 1. cfg_addr is {bus, devfn, offset}, cfg_map bit 0 is 1, and cfg_map[15:4] is 0.
- R8: Every result carries the configuration type code 3'b101 in cfg_map[3:1].
- R9: In any cycle that follows a cycle without req, cfg_addr and cfg_map keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe; the fields are sampled in the same cycle |
| bus | input | 8 | Target bus number |
| devfn | input | 8 | Slot in [7:3], function in [2:0] |
| offset | input | 8 | Configuration register offset |
| valid | output | 1 | Result strobe, high for one cycle per request |
| cfg_addr | output | 24 | Offset into the configuration window |
| cfg_map | output | 16 | Value for the window's map register |

## Verification
If the controller is stuck in, or wrongly enters, ST_EMIT or ST_IDLE, the valid strobe goes wrong in the cycle right after the request, or after a gap. The bench compares valid against the request of the previous edge on every cycle. A wrong select split, a wrong type flag or a wrong offset capture shows up in the very result that carries it. That result is checked at its valid strobe against a value computed independently. Slots 12, 13, 20 and 21 probe every edge of the split. Idle cycles then expose any output register that is not held.

// File: rtl/cfgaddr_pkg.sv
package cfgaddr_pkg;
    localparam int CFG_BUS_W    = 8;
    localparam int CFG_DEVFN_W  = 8;
    localparam int CFG_OFF_W    = 8;
    localparam int CFG_FN_W     = 3;
    localparam int CFG_ADDR_W   = 24;
    localparam int CFG_MAP_W    = 16;
    localparam logic [2:0] CFG_TYPE_CODE = 3'b101;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/cfgaddr_select.sv
module cfgaddr_select #(
    parameter int SLOT_W        = 5,
    parameter int ADDR_W        = 24,
    parameter int MAP_W         = 16,
    parameter int LOW_SLOT_MAX  = 12,
    parameter int ADDR_SEL_BASE = 11,
    parameter int MAP_SEL_SHIFT = 5
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic              local_seg,
    output logic [ADDR_W-1:0] addr_sel,
    output logic [MAP_W-1:0]  map_sel
);
    localparam int NSLOTS = 1 << SLOT_W;

    logic [NSLOTS-1:0] slot_hot;

    always_comb begin
        slot_hot = '0;
        slot_hot[slot] = local_seg;
    end

    for (genvar b = 0; b < ADDR_W; b++) begin : g_addr_bit
        if (b >= ADDR_SEL_BASE && (b - ADDR_SEL_BASE) <= LOW_SLOT_MAX &&
            (b - ADDR_SEL_BASE) < NSLOTS) begin : g_sel
            assign addr_sel[b] = slot_hot[b - ADDR_SEL_BASE];
        end else begin : g_zero
            assign addr_sel[b] = 1'b0;
        end
    end

    for (genvar b = 0; b < MAP_W; b++) begin : g_map_bit
        if ((b + MAP_SEL_SHIFT) > LOW_SLOT_MAX &&
            (b + MAP_SEL_SHIFT) < NSLOTS) begin : g_sel
            assign map_sel[b] = slot_hot[b + MAP_SEL_SHIFT];
        end else begin : g_zero
            assign map_sel[b] = 1'b0;
        end
    end
endmodule

// File: rtl/cfgaddr_compose.sv
module cfgaddr_compose
    import cfgaddr_pkg::*;
#(
    parameter int BUS_W   = CFG_BUS_W,
    parameter int DEVFN_W = CFG_DEVFN_W,
    parameter int OFF_W   = CFG_OFF_W,
    parameter int FN_W    = CFG_FN_W,
    parameter int ADDR_W  = CFG_ADDR_W,
    parameter int MAP_W   = CFG_MAP_W
) (
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [OFF_W-1:0]   offset,
    input  logic               local_seg,
    input  logic [ADDR_W-1:0]  addr_sel,
    input  logic [MAP_W-1:0]   map_sel,
    output logic [ADDR_W-1:0]  addr,
    output logic [MAP_W-1:0]   map
);
    localparam int T1_W = BUS_W + DEVFN_W + OFF_W;
    localparam int T0_W = FN_W + OFF_W;

    logic [T1_W-1:0] t1_word;
    logic [T0_W-1:0] t0_word;

    always_comb begin
        t1_word = {bus, devfn, offset};
        t0_word = {devfn[FN_W-1:0], offset[OFF_W-1:2], 2'b00};
        map     = map_sel;
        map[3:1] = CFG_TYPE_CODE;
        map[0]  = ~local_seg;
        if (local_seg) begin
            addr = ADDR_W'(t0_word) | addr_sel;
        end else begin
            addr = ADDR_W'(t1_word);
        end
    end
endmodule

// File: rtl/cfgaddr_gen.sv
module cfgaddr_gen
    import cfgaddr_pkg::*;
#(
    parameter int BUS_W         = CFG_BUS_W,
    parameter int DEVFN_W       = CFG_DEVFN_W,
    parameter int OFF_W         = CFG_OFF_W,
    parameter int FN_W          = CFG_FN_W,
    parameter int ADDR_W        = CFG_ADDR_W,
    parameter int MAP_W         = CFG_MAP_W,
    parameter int LOW_SLOT_MAX  = 12,
    parameter int ADDR_SEL_BASE = 11,
    parameter int MAP_SEL_SHIFT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [OFF_W-1:0]   offset,
    output logic               valid,
    output logic [ADDR_W-1:0]  cfg_addr,
    output logic [MAP_W-1:0]   cfg_map
);
    localparam int SLOT_W = DEVFN_W - FN_W;

    cfg_state_e        state_q;
    cfg_state_e        state_d;
    logic              local_seg;
    logic [ADDR_W-1:0] addr_sel;
    logic [MAP_W-1:0]  map_sel;
    logic [ADDR_W-1:0] addr_next;
    logic [MAP_W-1:0]  map_next;

    assign local_seg = (bus == '0);

    cfgaddr_select #(
        .SLOT_W       (SLOT_W),
        .ADDR_W       (ADDR_W),
        .MAP_W        (MAP_W),
        .LOW_SLOT_MAX (LOW_SLOT_MAX),
        .ADDR_SEL_BASE(ADDR_SEL_BASE),
        .MAP_SEL_SHIFT(MAP_SEL_SHIFT)
    ) u_select (
        .slot     (devfn[DEVFN_W-1:FN_W]),
        .local_seg(local_seg),
        .addr_sel (addr_sel),
        .map_sel  (map_sel)
    );

    cfgaddr_compose #(
        .BUS_W  (BUS_W),
        .DEVFN_W(DEVFN_W),
        .OFF_W  (OFF_W),
        .FN_W   (FN_W),
        .ADDR_W (ADDR_W),
        .MAP_W  (MAP_W)
    ) u_compose (
        .bus      (bus),
        .devfn    (devfn),
        .offset   (offset),
        .local_seg(local_seg),
        .addr_sel (addr_sel),
        .map_sel  (map_sel),
        .addr     (addr_next),
        .map      (map_next)
    );

    // Next-state logic: IDLE_WAIT, IDLE_TO_EMIT, EMIT_HOLD, EMIT_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers: loaded on a request, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_addr <= '0;
            cfg_map  <= '0;
        end else if (req) begin
            cfg_addr <= addr_next;
            cfg_map  <= map_next;
        end
    end

    assign valid = (state_q == ST_EMIT);
endmodule

// File: rtl/cfgaddr_gen_chk.sv
module cfgaddr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic [7:0]  bus,
    input logic        valid,
    input logic [23:0] cfg_addr,
    input logic [15:0] cfg_map
);
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) req |=> valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !req |=> !valid); // R2
    AST_TYPE_CODE: assert property (@(posedge clk) disable iff (!rst_n) valid |-> cfg_map[3:1] == 3'b101); // R8
    AST_LOCAL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) valid && !cfg_map[0] |-> cfg_addr[1:0] == 2'b00); // R3
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n) valid && !cfg_map[0] |-> $onehot0({cfg_addr[23:11], cfg_map[15:4]})); // R4
    AST_FWD_FLAG: assert property (@(posedge clk) disable iff (!rst_n) req && bus != 8'd0 |=> cfg_map[0] && cfg_map[15:4] == 12'd0); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req |=> $stable(cfg_addr) && $stable(cfg_map)); // R9
endmodule

bind cfgaddr_gen cfgaddr_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .bus     (bus),
    .valid   (valid),
    .cfg_addr(cfg_addr),
    .cfg_map (cfg_map)
);

// File: tb/cfgaddr_gen_test.sv
module cfgaddr_gen_test;
    typedef struct {
        logic [23:0] addr;
        logic [15:0] map;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [7:0]  bus = '0;
    logic [7:0]  devfn = '0;
    logic [7:0]  offset = '0;
    logic        valid;
    logic [23:0] cfg_addr;
    logic [15:0] cfg_map;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #4 clk = ~clk;

    cfgaddr_gen uut (
        .clk(clk), .rst_n(rst_n), .req(req), .bus(bus), .devfn(devfn),
        .offset(offset), .valid(valid), .cfg_addr(cfg_addr), .cfg_map(cfg_map)
    );

    task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [7:0] b, input logic [7:0] df, input logic [7:0] off, input string tag);
        exp_t e;
        int slot;
        slot = int'(df[7:3]);
        e.tag = tag;
        if (b != 8'd0) begin
            e.addr = {b, df, off};
            e.map  = 16'h000B;
        end else begin
            e.addr = {13'd0, df[2:0], off[7:2], 2'b00};
            e.map  = 16'h000A;
            if (slot <= 12) e.addr[slot + 11] = 1'b1;
            else if (slot <= 20) e.map[slot - 5] = 1'b1;
        end
        return e;
    endfunction

    task automatic send(input logic [7:0] b, input logic [7:0] df, input logic [7:0] off, input string tag);
        exp_t e;
        e = model(b, df, off, tag);
        sb_q.push_back(e);
        last_exp = e;
        req = 1'b1; bus = b; devfn = df; offset = off;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req = 1'b0; bus = 8'hA5; devfn = 8'h5A; offset = 8'hFF;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: valid must follow last edge's req (R2); results popped from scoreboard
    initial begin
        logic r;
        exp_t e;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            r = req;
            #1;
            check(valid === r, "R2 valid timing", {39'd0, valid}, {39'd0, r});
            if (valid === 1'b1) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2 valid with no request", 40'd1, 40'd0);
                end else begin
                    e = sb_q.pop_front();
                    check(cfg_addr === e.addr && cfg_map === e.map, e.tag,
                          {cfg_addr, cfg_map}, {e.addr, e.map});
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid === 1'b0 && cfg_addr === 24'd0 && cfg_map === 16'd0, "R1 reset",
              {cfg_addr, cfg_map}, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid === 1'b0 && cfg_addr === 24'd0 && cfg_map === 16'd0, "R1 after reset",
              {cfg_addr, cfg_map}, 40'd0);
        // R3 R4: local segment, low slots, offset low bits discarded
        send(8'd0, {5'd0, 3'd0}, 8'h00, "R4 slot0");
        idle(1);
        send(8'd0, {5'd5, 3'd6}, 8'h47, "R3 slot5 fn6 off47");
        idle(2);
        send(8'd0, {5'd12, 3'd7}, 8'hFF, "R4 slot12 edge");
        // R5: high slots back-to-back with the previous
        send(8'd0, {5'd13, 3'd1}, 8'h10, "R5 slot13 edge");
        send(8'd0, {5'd20, 3'd2}, 8'h3E, "R5 slot20 edge");
        // R6: no select bit
        send(8'd0, {5'd21, 3'd3}, 8'h08, "R6 slot21");
        send(8'd0, {5'd31, 3'd7}, 8'hFD, "R6 slot31");
        idle(1);
        // R7: forwarded
        send(8'd1, {5'd0, 3'd0}, 8'h03, "R7 bus1");
        send(8'hFF, 8'hFF, 8'hFF, "R7 bus255");
        send(8'h3C, {5'd12, 3'd5}, 8'h41, "R7 bus3C slot12");
        idle(1);
        send(8'd0, {5'd16, 3'd4}, 8'h2B, "R8 slot16");
        idle(4);
        check(cfg_addr === last_exp.addr && cfg_map === last_exp.map, "R9 hold after idle",
              {cfg_addr, cfg_map}, {last_exp.addr, last_exp.map});
        for (int s = 0; s < 32; s++) begin
            send(8'd0, {5'(s), 3'(s % 8)}, 8'(s * 7), "R4 R5 R6 slot sweep");
        end
        idle(3);
        check(cfg_addr === last_exp.addr && cfg_map === last_exp.map, "R9 hold after sweep",
              {cfg_addr, cfg_map}, {last_exp.addr, last_exp.map});
        check(sb_q.size() == 0, "R2 all results delivered", 40'(sb_q.size()), 40'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "watchdog", 40'd0, 40'd1);
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule